// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block sits in a host bridge and decides, access by access, whether a memory request in the upper legacy window (0xC0000 up to 0xFFFFF) is served by system DRAM or by the ROM/bus side. Seven byte-wide attribute registers live in the bridge's configuration space. Each register carries two 4-bit fields, and each field governs one address area. Within a field, reads and writes are enabled separately. This lets firmware copy its ROM image into DRAM. It writes into DRAM while reads still come from ROM, then turns on DRAM reads, and from then on the fast copy is used.

A single incoming request is routed within the same cycle to exactly one of two downstream ports. Read data from the chosen port is returned through the block. Configuration writes carry a two-bit nibble enable, so one area can be changed without touching its neighbour.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset, a configuration read of any offset from 0x59 to 0x5F returns 0x00. With those values, every access inside the window goes to the ROM/bus port.
- R2: A configuration write to an offset from 0x59 to 0x5F with both nibble enables set stores the whole data byte. A configuration read returns the stored byte. A write to any other offset changes no register, and a read of any other offset returns 0x00.
- R3: Area i is held in the register at offset 0x59 + i/2. An even i uses bits 3:0 and an odd i uses bits 7:4. Nibble enable bit 0 gates bits 3:0 and bit 1 gates bits 7:4. A nibble whose enable is clear keeps its value.
- R4: Area 1 is 0xF0000–0xFFFFF. Areas 2 to 13 are consecutive 16 KB blocks from 0xC0000 up to 0xEFFFF, in ascending order. Area 0 governs no address.
- R5: Within the window, a read goes to the DRAM port and returns DRAM data when bit 0 of its area field is 1. Otherwise it goes to the ROM/bus port and returns ROM/bus data.
- R6: Within the window, a write goes to the DRAM port when bit 1 of its area field is 1. Otherwise it goes to the ROM/bus port, and DRAM keeps its prior content.
- R7: An address below 0xC0000 always goes to the DRAM port, whatever the attribute values.
- R8: A register write changes routing from the cycle after its strobe. A request in the same cycle as the strobe uses the old value, and the registers hold their value in any cycle without a strobe.
- R9: Each valid request drives exactly one downstream port, carrying the request's address, direction and write data. With no request, neither port is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_nib_en | input | 2 | Nibble enables for a configuration write (bit 0 = low, bit 1 = high) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Configuration read data for cfg_off |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request byte address |
| req_wdata | input | 8 | Request write data |
| req_rdata | output | 8 | Read data returned to the requester |
| dram_valid | output | 1 | Request to DRAM |
| dram_write | output | 1 | DRAM write |
| dram_addr | output | 20 | DRAM address |
| dram_wdata | output | 8 | DRAM write data |
| dram_rdata | input | 8 | DRAM read data |
| rom_valid | output | 1 | Request to ROM/bus |
| rom_write | output | 1 | ROM/bus write |
| rom_addr | output | 20 | ROM/bus address |
| rom_wdata | output | 8 | ROM/bus write data |
| rom_rdata | input | 8 | ROM/bus read data |

## Verification
Some properties are checked on every cycle: only one port is active per request, a write to an unused offset leaves the registers unchanged, low addresses always reach DRAM, the zero state is reached after reset, byte and partial-nibble updates land correctly, and the registers stay stable without a strobe. The bench scenarios cover the rest. They confirm the area boundaries by probing the first and last byte of every area and the bytes just outside them. They walk the shadowing sequence (write-only, then read/write, then disabled) and show that ROM data returns once an area is switched off. They also show that a request in the same cycle as a configuration write still sees the old attributes.

// File: rtl/shadow_pkg.sv
// Shared constants and types for the shadow region attribute decoder.
package shadow_pkg;
    localparam int ADDR_W      = 20;
    localparam int NUM_REGS    = 7;
    localparam int CFG_BASE    = 8'h59;
    localparam int FIELD_W     = 4;
    localparam int SEG_LSB     = 14;
    localparam int NUM_AREAS   = NUM_REGS * 2;
    localparam int IDX_W       = $clog2(NUM_AREAS);

    // Destination picked for one request
    typedef enum logic {
        DEST_ROM  = 1'b0,
        DEST_DRAM = 1'b1
    } dest_e;

    // Meaningful bits of one area field
    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } area_perm_t;
endpackage

// File: rtl/shadow_attr_regs.sv
// Attribute register file: NUM_REGS bytes at consecutive configuration
// offsets from CFG_BASE. Writes are nibble-gated. Reads are combinational.
// Assumes cfg_off is stable while cfg_wr is high.
module shadow_attr_regs #(
    parameter int NUM_REGS = 7,
    parameter int CFG_BASE = 8'h59,
    localparam int FLAT_W  = NUM_REGS * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_off,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        cfg_nib_en,
    input  logic              cfg_wr,
    output logic [7:0]        cfg_rdata,
    output logic [FLAT_W-1:0] attr_flat
);
    logic [7:0] regs [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign hit[g] = (cfg_off == 8'(CFG_BASE + g));

        // Hold one attribute byte; update each nibble under its own enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (cfg_wr && hit[g]) begin
                if (cfg_nib_en[0]) regs[g][3:0] <= cfg_wdata[3:0];
                if (cfg_nib_en[1]) regs[g][7:4] <= cfg_wdata[7:4];
            end
        end

        assign attr_flat[g*8 +: 8] = regs[g];
    end

    // Return the byte at the addressed offset, zero elsewhere
    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit[k]) cfg_rdata = regs[k];
        end
    end
endmodule

// File: rtl/shadow_area_lookup.sv
// Maps a byte address to its attribute area. The window is the top quarter
// of the address space. Its last 64 KB segment is area 1, and the 16 KB
// blocks below it are areas 2 upward.
module shadow_area_lookup #(
    parameter int ADDR_W  = 20,
    parameter int SEG_LSB = 14,
    parameter int IDX_W   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic [IDX_W-1:0]  area_idx
);
    localparam int TOP_LSB = ADDR_W - 2;
    localparam int BLK_W   = TOP_LSB - SEG_LSB;

    logic [BLK_W-1:0] blk;

    assign blk = addr[TOP_LSB-1:SEG_LSB];

    // Decide window membership and area number
    always_comb begin
        in_window = (addr[ADDR_W-1:TOP_LSB] == 2'b11);
        if (addr[TOP_LSB-1:TOP_LSB-2] == 2'b11) begin
            area_idx = IDX_W'(1);
        end else begin
            area_idx = IDX_W'(2) + IDX_W'(blk);
        end
    end
endmodule

// File: rtl/shadow_attr_select.sv
// Selects the read and write enables of one area from the flat register
// image. Area 0 and unused index values yield no enables.
module shadow_attr_select
    import shadow_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int IDX_W    = 4,
    localparam int NUM_AREAS = NUM_REGS * 2,
    localparam int SLOTS     = 2 ** IDX_W
) (
    input  logic [NUM_REGS*8-1:0] attr_flat,
    input  logic [IDX_W-1:0]      area_idx,
    output area_perm_t            perm
);
    area_perm_t slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i > 0 && i < NUM_AREAS) begin : g_live
            assign slot[i] = area_perm_t'(attr_flat[(i/2)*8 + (i%2)*4 +: 2]);
        end else begin : g_dead
            assign slot[i] = '0;
        end
    end

    assign perm = slot[area_idx];
endmodule

// File: rtl/shadow_route.sv
// Steers a request to DRAM or ROM/bus from its direction and the area
// enables, and returns read data from the chosen side in the same cycle.
module shadow_route
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic [7:0]        req_rdata,
    input  logic              in_window,
    input  area_perm_t        perm,
    output logic              dram_valid,
    output logic              dram_write,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [7:0]        dram_wdata,
    input  logic [7:0]        dram_rdata,
    output logic              rom_valid,
    output logic              rom_write,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [7:0]        rom_wdata,
    input  logic [7:0]        rom_rdata
);
    dest_e dest;

    // Pick destination per direction
    always_comb begin
        if (!in_window) begin
            dest = DEST_DRAM;
        end else if (req_write) begin
            dest = perm.wr_en ? DEST_DRAM : DEST_ROM;
        end else begin
            dest = perm.rd_en ? DEST_DRAM : DEST_ROM;
        end
    end

    // Drive both downstream ports and the return path
    always_comb begin
        dram_valid = req_valid && (dest == DEST_DRAM);
        rom_valid  = req_valid && (dest == DEST_ROM);
        dram_write = req_write;
        rom_write  = req_write;
        dram_addr  = req_addr;
        rom_addr   = req_addr;
        dram_wdata = req_wdata;
        rom_wdata  = req_wdata;
        req_rdata  = (dest == DEST_DRAM) ? dram_rdata : rom_rdata;
    end
endmodule

// File: rtl/shadow_attr_decoder.sv
// Top level: attribute registers, address lookup, field select and routing.
// Assumes downstream ports return read data in the same cycle.
module shadow_attr_decoder
    import shadow_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          cfg_off,
    input  logic [7:0]          cfg_wdata,
    input  logic [1:0]          cfg_nib_en,
    input  logic                cfg_wr,
    output logic [7:0]          cfg_rdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [7:0]          req_wdata,
    output logic [7:0]          req_rdata,
    output logic                dram_valid,
    output logic                dram_write,
    output logic [ADDR_W-1:0]   dram_addr,
    output logic [7:0]          dram_wdata,
    input  logic [7:0]          dram_rdata,
    output logic                rom_valid,
    output logic                rom_write,
    output logic [ADDR_W-1:0]   rom_addr,
    output logic [7:0]          rom_wdata,
    input  logic [7:0]          rom_rdata
);
    logic [NUM_REGS*8-1:0] attr_flat;
    logic                  in_window;
    logic [IDX_W-1:0]      area_idx;
    area_perm_t            perm;

    shadow_attr_regs #(.NUM_REGS(NUM_REGS), .CFG_BASE(CFG_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata),
        .cfg_nib_en(cfg_nib_en), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
        .attr_flat(attr_flat)
    );

    shadow_area_lookup #(.ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB), .IDX_W(IDX_W)) u_lookup (
        .addr(req_addr), .in_window(in_window), .area_idx(area_idx)
    );

    shadow_attr_select #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_select (
        .attr_flat(attr_flat), .area_idx(area_idx), .perm(perm)
    );

    shadow_route #(.ADDR_W(ADDR_W)) u_route (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rdata(req_rdata),
        .in_window(in_window), .perm(perm),
        .dram_valid(dram_valid), .dram_write(dram_write), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .rom_valid(rom_valid), .rom_write(rom_write), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
    );
endmodule

// File: rtl/shadow_attr_decoder_chk.sv
// Checker for the decoder, attached by bind. It watches the ports and the
// register image and holds no state beyond one registered offset.
module shadow_attr_decoder_chk
    import shadow_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            cfg_off,
    input logic [7:0]            cfg_wdata,
    input logic [1:0]            cfg_nib_en,
    input logic                  cfg_wr,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  dram_valid,
    input logic                  rom_valid,
    input logic [NUM_REGS*8-1:0] attr_flat
);
    logic [7:0] idx_now;
    logic [7:0] idx_q;
    logic [7:0] sel_now;
    logic [7:0] sel_q;
    logic       in_range;

    assign idx_now  = cfg_off - 8'(CFG_BASE);
    assign in_range = (idx_now < 8'(NUM_REGS));
    assign sel_now  = 8'(attr_flat >> (idx_now * 8));
    assign sel_q    = 8'(attr_flat >> (idx_q * 8));

    // Remember last cycle's register index
    always_ff @(posedge clk) begin
        idx_q <= idx_now;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> attr_flat == '0);

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && in_range && cfg_nib_en == 2'b11) |=> sel_q == $past(cfg_wdata));

    // R2
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !in_range) |=> $stable(attr_flat));

    // R3
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && in_range && cfg_nib_en == 2'b01) |=>
            (sel_q[7:4] == $past(sel_now[7:4])) && (sel_q[3:0] == $past(cfg_wdata[3:0])));

    // R7
    low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < 20'hC0000) |-> dram_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(attr_flat));

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({dram_valid, rom_valid}) == 1);

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !dram_valid && !rom_valid);
endmodule

bind shadow_attr_decoder shadow_attr_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata),
    .cfg_nib_en(cfg_nib_en), .cfg_wr(cfg_wr), .req_valid(req_valid),
    .req_addr(req_addr), .dram_valid(dram_valid), .rom_valid(rom_valid),
    .attr_flat(attr_flat)
);

// File: tb/shadow_attr_decoder_bench.sv
`timescale 1ns/1ps
module shadow_attr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_off = '0, cfg_wdata = '0;
    logic [1:0]  cfg_nib_en = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, req_rdata;
    logic        dram_valid, dram_write, rom_valid, rom_write;
    logic [19:0] dram_addr, rom_addr;
    logic [7:0]  dram_wdata, rom_wdata, dram_rdata, rom_rdata;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        bit         wr;
        bit         to_dram;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [7:0] dram_mem [4096];
    logic [7:0] exp_mem  [4096];
    logic [7:0] attr_m   [7];

    always #2.5 clk = ~clk;

    shadow_attr_decoder u_shadow_attr_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata),
        .cfg_nib_en(cfg_nib_en), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rdata(req_rdata),
        .dram_valid(dram_valid), .dram_write(dram_write), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .rom_valid(rom_valid), .rom_write(rom_write), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
    );

    function automatic int key(input logic [19:0] a);
        return int'({a[19:14], a[5:0]});
    endfunction

    // DRAM and ROM/bus models
    assign dram_rdata = dram_mem[key(dram_addr)];
    assign rom_rdata  = rom_addr[7:0] ^ 8'h5A;
    always @(posedge clk) if (dram_valid && dram_write) dram_mem[key(dram_addr)] <= dram_wdata;

    function automatic int area_of(input logic [19:0] a);
        if (a >= 20'hF0000) return 1;
        if (a >= 20'hE0000) return 10 + int'((a - 20'hE0000) / 20'h4000);
        if (a >= 20'hC0000) return 2 + int'((a - 20'hC0000) / 20'h4000);
        return -1;
    endfunction

    function automatic bit exp_dram(input logic [19:0] a, input bit wr);
        int ar;
        logic [7:0] f;
        ar = area_of(a);
        if (ar < 0) return 1'b1;
        f = attr_m[ar/2] >> ((ar % 2) * 4);
        return wr ? f[1] : f[0];
    endfunction

    function automatic void chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endfunction

    // Driver: one cycle of stimulus plus scoreboard push
    task automatic cycle(input bit cw, input logic [7:0] co, input logic [7:0] cd,
                         input logic [1:0] ne, input bit rv, input bit rw,
                         input logic [19:0] ra, input logic [7:0] rd, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cfg_wr = cw; cfg_off = co; cfg_wdata = cd; cfg_nib_en = ne;
        req_valid = rv; req_write = rw; req_addr = ra; req_wdata = rd;
        if (rv) begin
            e.wr = rw;
            e.to_dram = exp_dram(ra, rw);
            e.tag = tag;
            if (rw) e.data = rd;
            else e.data = e.to_dram ? exp_mem[key(ra)] : (ra[7:0] ^ 8'h5A);
            if (rw && e.to_dram) exp_mem[key(ra)] = rd;
            sb.push_back(e);
        end
        if (cw && co >= 8'h59 && co <= 8'h5F) begin
            if (ne[0]) attr_m[co - 8'h59][3:0] = cd[3:0];
            if (ne[1]) attr_m[co - 8'h59][7:4] = cd[7:4];
        end
    endtask

    task automatic idle();
        cycle(0, 8'h00, 8'h00, 2'b00, 0, 0, 20'h0, 8'h00, "");
    endtask

    task automatic cfg_write(input logic [7:0] off, input logic [7:0] d, input logic [1:0] ne);
        cycle(1, off, d, ne, 0, 0, 20'h0, 8'h00, "");
    endtask

    task automatic set_area(input int ar, input logic [3:0] v);
        cfg_write(8'(8'h59 + ar/2), (ar % 2) ? {v, 4'h0} : {4'h0, v}, (ar % 2) ? 2'b10 : 2'b01);
    endtask

    task automatic mem_rd(input logic [19:0] a, input string tag);
        cycle(0, 8'h00, 8'h00, 2'b00, 1, 0, a, 8'h00, tag);
    endtask

    task automatic mem_wr(input logic [19:0] a, input logic [7:0] d, input string tag);
        cycle(0, 8'h00, 8'h00, 2'b00, 1, 1, a, d, tag);
    endtask

    task automatic cfg_chk(input logic [7:0] off, input logic [7:0] exp, input string tag);
        cycle(0, off, 8'h00, 2'b00, 0, 0, 20'h0, 8'h00, "");
        @(negedge clk);
        chk(cfg_rdata == exp, tag, 32'(cfg_rdata), 32'(exp));
    endtask

    // Monitor: pop and compare each request away from the clock edge
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected request", 32'(req_addr), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(dram_valid == e.to_dram && rom_valid == !e.to_dram,
                    {e.tag, " port"}, {30'h0, dram_valid, rom_valid}, {30'h0, e.to_dram, !e.to_dram});
                if (!e.wr)
                    chk(req_rdata == e.data, {e.tag, " rdata"}, 32'(req_rdata), 32'(e.data));
                else if (e.to_dram)
                    chk(dram_write && dram_wdata == e.data && dram_addr == req_addr,
                        {e.tag, " dram write"}, 32'(dram_wdata), 32'(e.data));
                else
                    chk(rom_write && rom_wdata == e.data && rom_addr == req_addr,
                        {e.tag, " rom write"}, 32'(rom_wdata), 32'(e.data));
            end
        end
    end

    // Watchdog
    initial begin
        #(5ns * 100000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [19:0] st, en;
        for (int i = 0; i < 4096; i++) begin dram_mem[i] = '0; exp_mem[i] = '0; end
        for (int i = 0; i < 7; i++) attr_m[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values and default routing to ROM/bus
        for (int i = 0; i < 7; i++) cfg_chk(8'(8'h59 + i), 8'h00, "R1 reset reg");
        mem_rd(20'hC0010, "R1 default read");
        mem_rd(20'hF8000, "R1 default read");

        // R6: write with write-enable clear leaves DRAM untouched
        mem_wr(20'hC4000, 8'h77, "R6 write to rom");

        // R2: full byte write, readback, stray offsets
        cfg_write(8'h5C, 8'hA5, 2'b11);
        cfg_chk(8'h5C, 8'hA5, "R2 byte readback");
        cfg_write(8'h58, 8'hFF, 2'b11);
        cfg_write(8'h60, 8'hFF, 2'b11);
        cfg_chk(8'h58, 8'h00, "R2 stray offset read");
        cfg_chk(8'h60, 8'h00, "R2 stray offset read");
        for (int i = 0; i < 7; i++) cfg_chk(8'(8'h59 + i), (i == 3) ? 8'hA5 : 8'h00, "R2 untouched regs");
        cfg_write(8'h5C, 8'h00, 2'b11);

        // R3: nibble-gated writes keep the other nibble
        cfg_write(8'h5A, 8'hF2, 2'b10);
        cfg_chk(8'h5A, 8'hF0, "R3 high nibble only");
        cfg_write(8'h5A, 8'h31, 2'b01);
        cfg_chk(8'h5A, 8'hF1, "R3 low nibble only");
        cfg_write(8'h5A, 8'hCC, 2'b00);
        cfg_chk(8'h5A, 8'hF1, "R3 no enables");
        cfg_write(8'h5A, 8'h00, 2'b11);

        // R5 R6: shadowing sequence on area 3 (0xC4000)
        set_area(3, 4'h2);
        mem_wr(20'hC4000, 8'h42, "R6 write-only area to dram");
        mem_rd(20'hC4000, "R5 read still rom");
        set_area(3, 4'h3);
        mem_rd(20'hC4000, "R5 read shadow copy");
        mem_wr(20'hC4000, 8'h82, "R6 rewrite");
        mem_rd(20'hC4000, "R5 read new copy");
        set_area(3, 4'h1);
        mem_wr(20'hC4000, 8'h99, "R6 write blocked");
        mem_rd(20'hC4000, "R6 dram kept prior value");
        set_area(3, 4'h0);
        mem_rd(20'hC4000, "R5 copy hidden");

        // R4: area 0 governs nothing
        set_area(0, 4'h3);
        mem_rd(20'hC0000, "R4 area0 no effect");
        mem_rd(20'hFFFFF, "R4 area0 no effect");
        set_area(0, 4'h0);

        // R4: sweep every area with boundary probes
        for (int ar = 1; ar < 14; ar++) begin
            st = (ar == 1) ? 20'hF0000 : 20'(20'hC0000 + (ar - 2) * 20'h4000);
            en = (ar == 1) ? 20'hFFFFF : 20'(st + 20'h3FFF);
            set_area(ar, 4'h3);
            mem_wr(st, 8'(ar), "R4 area start write");
            mem_wr(en, 8'(ar + 8'h80), "R4 area end write");
            mem_rd(st, "R4 area start read");
            mem_rd(en, "R4 area end read");
            mem_rd(20'(st - 1), "R4 below area");
            if (en != 20'hFFFFF) mem_rd(20'(en + 1), "R4 above area");
            set_area(ar, 4'h0);
            mem_rd(st, "R4 area disabled");
        end

        // R7: low addresses always DRAM
        for (int i = 0; i < 7; i++) cfg_write(8'(8'h59 + i), 8'h00, 2'b11);
        mem_wr(20'h12345, 8'h3C, "R7 low write");
        mem_rd(20'h12345, "R7 low read");
        mem_wr(20'hBFFFF, 8'h6D, "R7 edge write");
        mem_rd(20'hBFFFF, "R7 edge read");

        // R8: same-cycle request sees old value, next cycle sees new
        mem_wr(20'hD8000, 8'h55, "R8 write to rom");
        cycle(1, 8'h5D, 8'h01, 2'b01, 1, 0, 20'hD8000, 8'h00, "R8 same cycle old");
        mem_rd(20'hD8000, "R8 next cycle new");

        idle();
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule